// File: doc/BRIEF.md
# Multi-pass stripe alignment engine

This block scores the extension of an exact-match seed with a local-alignment dynamic program under affine gap penalties. A read (the columns of the score matrix) is compared against a target window (the rows), starting from a nonzero seed score at the corner. The engine returns the best cell score anywhere in the matrix with its position, and the best score reached in the read's final column with its row.

A fixed group of `NPE` processing elements (32 by default) emulates an array as long as the read. The group works through the matrix one vertical stripe of `NPE` read symbols at a time. The final column of each stripe is written into an on-chip row buffer, and that buffer is replayed as the left edge of the next stripe. Each pass starts on the first cycle that has valid input. It ends on the cycle its last active element finishes its last row, so passes are trimmed instead of spanning the full wavefront. A read that fits in one stripe never touches the buffer.

The host places the sequences, lengths, seed score and penalties on the inputs and pulses `start`. It then waits for `done` and reads the results. Inputs must stay stable while `busy` is high.

Top module: `stripe_align_engine`

## Requirements
- R1: With the engine idle, a `start` pulse begins a run and `busy` rises on the same edge. Later, `done` is high for exactly one cycle, in the cycle after `busy` falls. The result outputs hold their values until the next accepted start. A `start` that arrives while `busy` is high is ignored.
- R2: Cell (i,j) computes the following, where x⁺ means max(x,0), Go is the gap-open penalty and Ge is the gap-extend penalty. The vertical gap is E = (max(H(i-1,j)−Go, E(i-1,j)) − Ge)⁺. The horizontal gap is F = (max(H(i,j-1)−Go, F(i,j-1)) − Ge)⁺. The cell score is H = max(D, E, F). D = H(i-1,j-1)+match_bonus when the 2-bit target symbol i equals read symbol j, and (H(i-1,j-1)−mismatch_pen)⁺ otherwise.
- R3: The matrix edges derive from the seed score S. H(-1,-1)=S. H(-1,j)=(S−Go−Ge·(j+1))⁺ and H(i,-1)=(S−Go−Ge·(i+1))⁺. E on the top edge and F on the left edge are 0.
- R4: `local_score` is the highest H over all cells, starting from S at position (0,0). Positions are reported as `local_row`=i+1 and `local_col`=j+1. Among equal scores the smaller row wins, then the smaller column, and the seed position wins every tie.
- R5: `global_score` is the highest H in column read_len−1, reported with `global_row`=i+1. Ties go to the smaller row. The value is 0 with row 0 when no such cell exceeds 0.
- R6: The read is processed in ceil(read_len/NPE) stripes. The results equal those of a single full-width sweep for every read length from 1 to MAX_QLEN, including exactly NPE and NPE+1 symbols.
- R7: Pass p has n_p = min(NPE, read_len−p·NPE) active columns and lasts target_len+n_p−1 cycles. `cycle_count` reports the sum over all passes, and `done` arrives that many cycles after the start edge.
- R8: Read symbols at positions ≥ read_len and target symbols at positions ≥ target_len have no effect on any result.
- R9: After reset, `busy` and `done` are 0 and every result output and `cycle_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted only while idle |
| read_seq | input | MAX_QLEN*SYM_W | Read symbols, symbol j at bits [j*SYM_W +: SYM_W] |
| target_seq | input | MAX_TLEN*SYM_W | Target symbols, symbol i at bits [i*SYM_W +: SYM_W] |
| read_len | input | clog2(MAX_QLEN+1) | Read length, 1 to MAX_QLEN |
| target_len | input | clog2(MAX_TLEN+1) | Target length, 1 to MAX_TLEN |
| seed_score | input | SCORE_W | Seed score S |
| match_bonus | input | PEN_W | Score added on a symbol match |
| mismatch_pen | input | PEN_W | Score removed on a mismatch |
| gap_open | input | PEN_W | Gap open penalty Go |
| gap_ext | input | PEN_W | Gap extend penalty Ge |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle result-valid pulse |
| local_score | output | SCORE_W | Best cell score |
| local_row | output | clog2(MAX_TLEN+1) | Row of best cell, 1-based (0 = seed) |
| local_col | output | clog2(MAX_QLEN+1) | Column of best cell, 1-based (0 = seed) |
| global_score | output | SCORE_W | Best score in the last read column |
| global_row | output | clog2(MAX_TLEN+1) | Row of that score, 1-based |
| cycle_count | output | CYC_W | Cycles spent in the last run |

## Verification
The bench targets read lengths of exactly 32, 33 and 64. At these lengths a wrong pass count or off-by-one stripe width either drops the final one-column stripe or replays a stale boundary row, which would shift the global score and its row. It also stores target symbols past the read length that would match, so an engine that failed to mask idle elements in the last partial stripe would report a higher local score. The bench measures the latency and `cycle_count` of each run against the trimmed per-pass formula, which catches passes that run the full rectangular wavefront or finish early. It also pulses `start` in the middle of a run, and a design that restarted would report a longer latency.

// File: rtl/stripe_pkg.sv
package stripe_pkg;

    localparam int SCORE_W = 12;
    localparam int PEN_W   = 6;

    typedef logic [SCORE_W-1:0] score_t;
    typedef logic [PEN_W-1:0]   pen_t;

    typedef struct packed {
        pen_t mat;
        pen_t mis;
        pen_t gopen;
        pen_t gext;
    } scoring_t;

    typedef struct packed {
        score_t h;
        score_t f;
    } edge_t;

    typedef enum logic {ST_IDLE, ST_SWEEP} phase_e;

    function automatic score_t clamp_score(int v);
        if (v <= 0) return '0;
        if (v >= (1 << SCORE_W) - 1) return '1;
        return score_t'(v);
    endfunction

    // score on the matrix edge n gap steps away from the seed
    function automatic score_t edge_score(score_t seed, scoring_t sc, int n);
        return clamp_score(int'(seed) - int'(sc.gopen) - int'(sc.gext) * n);
    endfunction

    function automatic score_t gap_score(score_t h, score_t g, scoring_t sc);
        int opened;
        int best;
        opened = int'(h) - int'(sc.gopen);
        best   = (opened > int'(g)) ? opened : int'(g);
        return clamp_score(best - int'(sc.gext));
    endfunction

    function automatic score_t diag_score(score_t hd, logic hit, scoring_t sc);
        return hit ? clamp_score(int'(hd) + int'(sc.mat))
                   : clamp_score(int'(hd) - int'(sc.mis));
    endfunction

    // total order on candidates: score, then smaller row, then smaller column
    function automatic logic beats(int s1, int r1, int c1, int s2, int r2, int c2);
        return (s1 > s2) || ((s1 == s2) && ((r1 < r2) || ((r1 == r2) && (c1 < c2))));
    endfunction

endpackage

// File: rtl/stripe_pe.sv
module stripe_pe import stripe_pkg::*; #(
    parameter int SYM_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             active,
    input  score_t           load_h,
    input  logic [SYM_W-1:0] qsym,
    input  logic [SYM_W-1:0] tsym,
    input  scoring_t         sc,
    input  score_t           left_h,
    input  score_t           left_f,
    input  score_t           left_d,
    output score_t           h_out,
    output score_t           f_out,
    output score_t           d_out,
    output score_t           cell_h,
    output score_t           cell_f
);
    score_t h_reg, hd_reg, e_reg, f_reg;
    score_t e_new, f_new, dg;

    always_comb begin
        e_new  = gap_score(h_reg, e_reg, sc);
        f_new  = gap_score(left_h, left_f, sc);
        dg     = diag_score(left_d, qsym == tsym, sc);
        cell_h = dg;
        if (e_new > cell_h) cell_h = e_new;
        if (f_new > cell_h) cell_h = f_new;
        cell_f = f_new;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            h_reg  <= '0;
            hd_reg <= '0;
            e_reg  <= '0;
            f_reg  <= '0;
        end else if (load) begin
            h_reg  <= load_h;
            hd_reg <= '0;
            e_reg  <= '0;
            f_reg  <= '0;
        end else if (active) begin
            hd_reg <= h_reg;
            h_reg  <= cell_h;
            e_reg  <= e_new;
            f_reg  <= f_new;
        end
    end

    assign h_out = h_reg;
    assign f_out = f_reg;
    assign d_out = hd_reg;

endmodule

// File: rtl/stripe_edge_buf.sv
module stripe_edge_buf import stripe_pkg::*; #(
    parameter int DEPTH = 160,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  edge_t         wdata,
    input  logic [AW-1:0] raddr,
    output edge_t         rdata
);
    edge_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/stripe_peak.sv
module stripe_peak import stripe_pkg::*; #(
    parameter int NPE = 32,
    parameter int RW  = 8,
    parameter int CW  = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      clear,
    input  score_t                    seed,
    input  logic [NPE-1:0]            cand_v,
    input  logic [NPE-1:0]            cand_g,
    input  logic [NPE-1:0][SCORE_W-1:0] cand_h,
    input  logic [NPE-1:0][RW-1:0]    cand_row,
    input  logic [NPE-1:0][CW-1:0]    cand_col,
    output score_t                    l_score,
    output logic [RW-1:0]             l_row,
    output logic [CW-1:0]             l_col,
    output score_t                    g_score,
    output logic [RW-1:0]             g_row
);
    score_t        bs, gs;
    logic [RW-1:0] br, gr;
    logic [CW-1:0] bc;

    always_comb begin
        bs = l_score; br = l_row; bc = l_col;
        gs = g_score; gr = g_row;
        for (int k = 0; k < NPE; k++) begin
            if (cand_v[k] && beats(int'(cand_h[k]), int'(cand_row[k]), int'(cand_col[k]),
                                   int'(bs), int'(br), int'(bc))) begin
                bs = cand_h[k]; br = cand_row[k]; bc = cand_col[k];
            end
            if (cand_g[k] && beats(int'(cand_h[k]), int'(cand_row[k]), 0,
                                   int'(gs), int'(gr), 0)) begin
                gs = cand_h[k]; gr = cand_row[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            l_score <= '0; l_row <= '0; l_col <= '0;
            g_score <= '0; g_row <= '0;
        end else if (clear) begin
            l_score <= seed; l_row <= '0; l_col <= '0;
            g_score <= '0;   g_row <= '0;
        end else begin
            l_score <= bs; l_row <= br; l_col <= bc;
            g_score <= gs; g_row <= gr;
        end
    end

endmodule

// File: rtl/stripe_align_engine.sv
module stripe_align_engine import stripe_pkg::*; #(
    parameter int NPE      = 32,
    parameter int SYM_W    = 2,
    parameter int MAX_QLEN = 128,
    parameter int MAX_TLEN = 160,
    parameter int CYC_W    = 16
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            start,
    input  logic [MAX_QLEN*SYM_W-1:0]       read_seq,
    input  logic [MAX_TLEN*SYM_W-1:0]       target_seq,
    input  logic [$clog2(MAX_QLEN+1)-1:0]   read_len,
    input  logic [$clog2(MAX_TLEN+1)-1:0]   target_len,
    input  logic [SCORE_W-1:0]              seed_score,
    input  logic [PEN_W-1:0]                match_bonus,
    input  logic [PEN_W-1:0]                mismatch_pen,
    input  logic [PEN_W-1:0]                gap_open,
    input  logic [PEN_W-1:0]                gap_ext,
    output logic                            busy,
    output logic                            done,
    output logic [SCORE_W-1:0]              local_score,
    output logic [$clog2(MAX_TLEN+1)-1:0]   local_row,
    output logic [$clog2(MAX_QLEN+1)-1:0]   local_col,
    output logic [SCORE_W-1:0]              global_score,
    output logic [$clog2(MAX_TLEN+1)-1:0]   global_row,
    output logic [CYC_W-1:0]                cycle_count
);
    localparam int QL_W     = $clog2(MAX_QLEN + 1);
    localparam int TL_W     = $clog2(MAX_TLEN + 1);
    localparam int MAX_PASS = (MAX_QLEN + NPE - 1) / NPE;
    localparam int PASS_W   = $clog2(MAX_PASS + 1);
    localparam int STEP_W   = $clog2(MAX_TLEN + NPE);
    localparam int ROW_AW   = $clog2(MAX_TLEN);

    scoring_t            sc;
    phase_e              phase;
    logic [PASS_W-1:0]   pass_idx;
    logic [STEP_W-1:0]   step;
    logic [CYC_W-1:0]    cyc;
    logic                done_r;
    score_t              feed_d, feed_h, feed_f;
    logic                running, accept, load, pass_end, last_pass;
    int                  npass, ncol, nxt_pass;
    edge_t               buf_rd, buf_wr;
    logic                buf_we;
    logic [ROW_AW-1:0]   buf_raddr, buf_waddr;

    score_t pe_h [NPE];
    score_t pe_f [NPE];
    score_t pe_d [NPE];
    score_t cell_h [NPE];
    score_t cell_f [NPE];
    logic [NPE-1:0]              act_v, glob_v;
    logic [NPE-1:0][SCORE_W-1:0] cand_h;
    logic [NPE-1:0][TL_W-1:0]    cand_row;
    logic [NPE-1:0][QL_W-1:0]    cand_col;

    assign sc = '{mat: match_bonus, mis: mismatch_pen, gopen: gap_open, gext: gap_ext};
    assign running = (phase == ST_SWEEP);
    assign accept  = (phase == ST_IDLE) && start;

    always_comb begin
        npass = (int'(read_len) + NPE - 1) / NPE;
        ncol  = int'(read_len) - int'(pass_idx) * NPE;
        if (ncol > NPE) ncol = NPE;
        pass_end  = running && (int'(step) == int'(target_len) + ncol - 2);
        last_pass = (int'(pass_idx) == npass - 1);
        load      = accept || (pass_end && !last_pass);
        nxt_pass  = running ? int'(pass_idx) + 1 : 0;
    end

    // left edge of the stripe: computed on the first pass, replayed afterwards
    always_comb begin
        if (pass_idx == '0) begin
            feed_h = edge_score(seed_score, sc, int'(step) + 1);
            feed_f = '0;
        end else begin
            feed_h = buf_rd.h;
            feed_f = buf_rd.f;
        end
    end

    assign buf_raddr = (int'(step) < MAX_TLEN) ? ROW_AW'(step) : '0;
    assign buf_we    = running && !last_pass && act_v[NPE-1];
    assign buf_waddr = ROW_AW'(int'(step) - (NPE - 1));
    assign buf_wr    = '{h: cell_h[NPE-1], f: cell_f[NPE-1]};

    stripe_edge_buf #(.DEPTH(MAX_TLEN), .AW(ROW_AW)) u_edge (
        .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wr),
        .raddr(buf_raddr), .rdata(buf_rd)
    );

    for (genvar k = 0; k < NPE; k++) begin : g_pe
        int               col_i, row_i;
        logic             act;
        logic [SYM_W-1:0] qs, ts;
        score_t           lh, lf, ld, ldh;

        always_comb begin
            col_i = int'(pass_idx) * NPE + k;
            row_i = int'(step) - k;
            act   = running && (k < ncol) && (row_i >= 0) && (row_i < int'(target_len));
            qs    = read_seq[((col_i < MAX_QLEN) ? col_i : MAX_QLEN - 1) * SYM_W +: SYM_W];
            ts    = target_seq[((row_i >= 0 && row_i < MAX_TLEN) ? row_i : 0) * SYM_W +: SYM_W];
            ldh   = edge_score(seed_score, sc, nxt_pass * NPE + k + 1);
        end

        if (k == 0) begin : g_first
            assign lh = feed_h;
            assign lf = feed_f;
            assign ld = feed_d;
        end else begin : g_chain
            assign lh = pe_h[k-1];
            assign lf = pe_f[k-1];
            assign ld = pe_d[k-1];
        end

        stripe_pe #(.SYM_W(SYM_W)) u_pe (
            .clk(clk), .rst(rst), .load(load), .active(act), .load_h(ldh),
            .qsym(qs), .tsym(ts), .sc(sc),
            .left_h(lh), .left_f(lf), .left_d(ld),
            .h_out(pe_h[k]), .f_out(pe_f[k]), .d_out(pe_d[k]),
            .cell_h(cell_h[k]), .cell_f(cell_f[k])
        );

        assign act_v[k]    = act;
        assign glob_v[k]   = act && (col_i == int'(read_len) - 1);
        assign cand_h[k]   = cell_h[k];
        assign cand_row[k] = TL_W'(row_i + 1);
        assign cand_col[k] = QL_W'(col_i + 1);
    end

    stripe_peak #(.NPE(NPE), .RW(TL_W), .CW(QL_W)) u_peak (
        .clk(clk), .rst(rst), .clear(accept), .seed(seed_score),
        .cand_v(act_v), .cand_g(glob_v), .cand_h(cand_h),
        .cand_row(cand_row), .cand_col(cand_col),
        .l_score(local_score), .l_row(local_row), .l_col(local_col),
        .g_score(global_score), .g_row(global_row)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= ST_IDLE;
            pass_idx <= '0;
            step     <= '0;
            cyc      <= '0;
            done_r   <= 1'b0;
            feed_d   <= '0;
        end else begin
            done_r <= 1'b0;
            if (load)
                feed_d <= (nxt_pass == 0) ? seed_score : edge_score(seed_score, sc, nxt_pass * NPE);
            else if (running && int'(step) < int'(target_len))
                feed_d <= feed_h;
            case (phase)
                ST_IDLE: if (start) begin
                    phase    <= ST_SWEEP;
                    pass_idx <= '0;
                    step     <= '0;
                    cyc      <= '0;
                end
                ST_SWEEP: begin
                    cyc <= cyc + CYC_W'(1);
                    if (pass_end) begin
                        step <= '0;
                        if (last_pass) begin
                            phase  <= ST_IDLE;
                            done_r <= 1'b1;
                        end else begin
                            pass_idx <= pass_idx + PASS_W'(1);
                        end
                    end else begin
                        step <= step + STEP_W'(1);
                    end
                end
                default: phase <= ST_IDLE;
            endcase
        end
    end

    assign busy        = running;
    assign done        = done_r;
    assign cycle_count = cyc;

endmodule

// File: rtl/stripe_align_checks.sv
module stripe_align_checks import stripe_pkg::*; #(
    parameter int NPE   = 32,
    parameter int QL_W  = 8,
    parameter int TL_W  = 8,
    parameter int CYC_W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               busy,
    input logic               done,
    input logic [QL_W-1:0]    read_len,
    input logic [TL_W-1:0]    target_len,
    input logic [SCORE_W-1:0] local_score,
    input logic [TL_W-1:0]    local_row,
    input logic [QL_W-1:0]    local_col,
    input logic [SCORE_W-1:0] global_score,
    input logic [TL_W-1:0]    global_row,
    input logic [CYC_W-1:0]   cycle_count
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);  // R1
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);  // R1
    AST_LOCAL_GROWS: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (local_score >= $past(local_score)));  // R4
    AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        done |-> (local_row <= target_len && local_col <= read_len && global_row <= target_len));  // R4
    AST_GLOBAL_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        done |-> (global_score <= local_score));  // R5
    AST_PASS_TRIMMED: assert property (@(posedge clk) disable iff (rst)
        done |-> (int'(cycle_count) <=
                  ((int'(read_len) + NPE - 1) / NPE) * (int'(target_len) + NPE - 1)));  // R7
endmodule

bind stripe_align_engine stripe_align_checks #(
    .NPE(NPE), .QL_W(QL_W), .TL_W(TL_W), .CYC_W(CYC_W)
) u_checks (
    .clk(clk), .rst(rst), .busy(busy), .done(done),
    .read_len(read_len), .target_len(target_len),
    .local_score(local_score), .local_row(local_row), .local_col(local_col),
    .global_score(global_score), .global_row(global_row),
    .cycle_count(cycle_count)
);

// File: tb/test_stripe_align_engine.sv
`timescale 1ns/1ps
module test_stripe_align_engine;
    localparam int NPE = 32;
    localparam int MQ  = 128;
    localparam int MT  = 160;

    typedef struct packed {
        int ql; int tl; int sd; int h0; int ma; int mm; int go; int ge;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{32, 40, 1, 20, 1, 4, 6, 1},
        '{33, 40, 2, 20, 1, 4, 6, 1},
        '{64, 70, 3, 30, 1, 4, 6, 1},
        '{5, 8, 4, 10, 2, 3, 3, 1},
        '{100, 120, 5, 25, 1, 4, 6, 1},
        '{1, 1, 6, 5, 1, 4, 6, 1},
        '{40, 20, 7, 15, 2, 2, 4, 2},
        '{128, 160, 8, 0, 1, 4, 6, 1}
    };

    logic clk = 0, rst = 1, start = 0;
    logic [MQ*2-1:0] read_seq;
    logic [MT*2-1:0] target_seq;
    logic [7:0] read_len, target_len;
    logic [11:0] seed_score;
    logic [5:0] match_bonus, mismatch_pen, gap_open, gap_ext;
    logic busy, done;
    logic [11:0] local_score, global_score;
    logic [7:0] local_row, local_col, global_row;
    logic [15:0] cycle_count;

    int checks = 0, errors = 0;
    int rd [MQ];
    int tg [MT];
    int e_ls, e_lr, e_lc, e_gs, e_gr;

    always #10 clk = ~clk;

    stripe_align_engine i_stripe_align_engine (
        .clk(clk), .rst(rst), .start(start), .read_seq(read_seq), .target_seq(target_seq),
        .read_len(read_len), .target_len(target_len), .seed_score(seed_score),
        .match_bonus(match_bonus), .mismatch_pen(mismatch_pen), .gap_open(gap_open),
        .gap_ext(gap_ext), .busy(busy), .done(done), .local_score(local_score),
        .local_row(local_row), .local_col(local_col), .global_score(global_score),
        .global_row(global_row), .cycle_count(cycle_count)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int cl(int v); return (v < 0) ? 0 : v; endfunction
    function automatic int mx(int a, int b); return (a > b) ? a : b; endfunction

    task automatic fill(input int sd);
        for (int j = 0; j < MQ; j++) rd[j] = (j * 5 + sd * 3 + j / 4) % 4;
        for (int i = 0; i < MT; i++) begin
            int src;
            src = (sd % 2 == 1 && i > 12) ? i - 1 : i;
            tg[i] = (src < MQ) ? rd[src] : (i * 3 + sd) % 4;
            if ((i * 7 + sd) % 9 == 0) tg[i] = (tg[i] + 1) % 4;
        end
    endtask

    // behavioural reference: full-width sweep, row-major, strict improvement
    task automatic model(input vec_t v);
        int hp [MQ];
        int ep [MQ];
        int hc [MQ];
        int ec [MQ];
        int hl, fl, hd, e, f, h, dg;
        e_ls = v.h0; e_lr = 0; e_lc = 0; e_gs = 0; e_gr = 0;
        for (int j = 0; j < v.ql; j++) begin
            hp[j] = cl(v.h0 - v.go - v.ge * (j + 1));
            ep[j] = 0;
        end
        for (int i = 0; i < v.tl; i++) begin
            hl = cl(v.h0 - v.go - v.ge * (i + 1));
            fl = 0;
            hd = (i == 0) ? v.h0 : cl(v.h0 - v.go - v.ge * i);
            for (int j = 0; j < v.ql; j++) begin
                e  = cl(mx(hp[j] - v.go, ep[j]) - v.ge);
                f  = cl(mx(hl - v.go, fl) - v.ge);
                dg = (tg[i] == rd[j]) ? hd + v.ma : cl(hd - v.mm);
                h  = mx(dg, mx(e, f));
                hd = hp[j];
                hc[j] = h; ec[j] = e; hl = h; fl = f;
                if (h > e_ls) begin e_ls = h; e_lr = i + 1; e_lc = j + 1; end
                if (j == v.ql - 1 && h > e_gs) begin e_gs = h; e_gr = i + 1; end
            end
            for (int j = 0; j < v.ql; j++) begin hp[j] = hc[j]; ep[j] = ec[j]; end
        end
    endtask

    function automatic int exp_cycles(vec_t v);
        int s = 0;
        for (int p = 0; p * NPE < v.ql; p++) s += v.tl + ((v.ql - p * NPE > NPE) ? NPE : v.ql - p * NPE) - 1;
        return s;
    endfunction

    task automatic run(input vec_t v, input int poke, output int lat);
        for (int j = 0; j < MQ; j++) read_seq[j*2 +: 2] = rd[j][1:0];
        for (int i = 0; i < MT; i++) target_seq[i*2 +: 2] = tg[i][1:0];
        read_len = 8'(v.ql); target_len = 8'(v.tl); seed_score = 12'(v.h0);
        match_bonus = 6'(v.ma); mismatch_pen = 6'(v.mm); gap_open = 6'(v.go); gap_ext = 6'(v.ge);
        start = 1;
        @(negedge clk);
        lat = 0;
        while (done !== 1'b1 && lat < 4000) begin
            start = (lat == poke);
            @(negedge clk);
            lat++;
        end
        start = 0;
        if (done !== 1'b1) begin
            checks++; errors++;
            $display("FAIL R1 run watchdog: actual %0d expected done", lat);
        end
    endtask

    task automatic compare(input vec_t v, input int lat, input string tag);
        model(v);
        check({tag, " R2 R3 R6 local_score"}, int'(local_score), e_ls);
        check({tag, " R4 local_row"}, int'(local_row), e_lr);
        check({tag, " R4 local_col"}, int'(local_col), e_lc);
        check({tag, " R5 global_score"}, int'(global_score), e_gs);
        check({tag, " R5 global_row"}, int'(global_row), e_gr);
        check({tag, " R7 cycle_count"}, int'(cycle_count), exp_cycles(v));
        check({tag, " R7 latency"}, lat, exp_cycles(v));
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL global watchdog: actual timeout expected finish");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int lat;
        int held;
        vec_t v;
        read_seq = '0; target_seq = '0; read_len = 8'd1; target_len = 8'd1;
        seed_score = '0; match_bonus = '0; mismatch_pen = '0; gap_open = '0; gap_ext = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // r9_ reset state
        check("R9 busy after reset", int'(busy), 0);
        check("R9 done after reset", int'(done), 0);
        check("R9 local_score after reset", int'(local_score), 0);
        check("R9 cycle_count after reset", int'(cycle_count), 0);

        for (int n = 0; n < 8; n++) begin
            v = VECS[n];
            fill(v.sd);
            run(v, (n == 2) ? 5 : -1, lat);   // vector 2 pokes start mid-run (R1)
            compare(v, lat, $sformatf("vec%0d q%0d t%0d", n, v.ql, v.tl));
            held = int'(local_score);
            @(negedge clk);
            check("R1 done drops after one cycle", int'(done), 0);
            check("R1 result held after done", int'(local_score), held);
        end

        // R8: scramble everything past both lengths; results must not move
        v = VECS[1];
        fill(v.sd);
        for (int j = v.ql; j < MQ; j++) rd[j] = 3 - rd[j];
        for (int i = v.tl; i < MT; i++) tg[i] = (tg[i] + 2) % 4;
        run(v, -1, lat);
        compare(v, lat, "R8 scrambled tails");

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule